// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-attached watchdog built around a 16-bit up-counter. Software writes a start value into the count register, picks one of eight clock divisors in the primary control register, and then sets the enable bit. From then on the counter advances once per divided clock tick. If software never reloads it, the count rolls over from 0xFFFF to 0x0000. The block then latches an overflow flag and pulses a reset request for one clock. To arm a timeout of N ticks, software loads 65536 minus N. Reading the count back tells software how much time is left.

Every register write must carry a fixed guard pattern in its upper bits. Writes with a wrong pattern change nothing. A keyed write to the count register does not land at once. It is held in a staging register until a fixed number of divided ticks have passed. During that window a busy bit in the primary control register reads as one. Software polls this bit before it enables the timer. A keyed count write made while the timer runs is the keep-alive refresh.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, every register reads zero and `wdt_rst_req` is low.
- R2: A write is ignored if its guard pattern is wrong. The count register needs 0x5A5A in bits 31:16. Both control registers need 0xA5A5A5 in bits 31:8.
- R3: A keyed write to the secondary control register (offset 0x8) stores bits 7:0. Reading it returns that byte, zero-extended to 32 bits.
- R4: A keyed write to the count register (offset 0x0) loads bits 15:0 as the new count once the pending period ends.
- R5: The busy bit is bit 5 of the primary control register. It reads 1 from the cycle after a keyed count write until PEND_TICKS (default 2) divided ticks have passed. During that time the count register still shows the old value. A new keyed count write restarts the period.
- R6: In the primary control register (offset 0x4), bit 7 is the enable and bits 2:0 are the divisor select. Both read back as written. Bits 6 and 3 read zero.
- R7: While enabled and not pending, the count rises by one per divided tick. Select values 0 to 7 give divisors 1, 4, 16, 32, 64, 128, 1024 and 4096.
- R8: Clearing the enable bit freezes the count. Setting it again resumes counting from the frozen value.
- R9: When an enabled count rolls over from 0xFFFF, two things happen on the same clock edge: bit 4 (overflow) of the primary control register sets, and `wdt_rst_req` goes high for exactly one cycle.
- R10: The overflow bit is cleared only by a keyed primary-control write with bit 4 at 0. Writing 1 leaves it unchanged. A new overflow on the same edge as a clear wins.
- R11: A keyed count write while enabled refreshes the timer. The old count keeps advancing through the pending period, and then the new value replaces it.
- R12: Only offsets 0x0, 0x4 and 0x8 are mapped. Any other offset reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one cycle per write |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, including the guard pattern |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The checks assume that a write strobe lasts one cycle and that `bus_addr`, `bus_we` and `bus_wdata` hold steady while `bus_sel` is high. The bench drives each access for exactly one clock, between falling edges. The counting checks assume that no count load lands inside the observed window. So the stimulus waits for the busy bit to clear before it enables the timer or measures ticks. It also measures divisors over whole multiples of the divisor, so the prescaler phase cannot change the expected tick count.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned PRE_W    = 12;   // log2 of the largest divisor
  localparam int unsigned SEL_W    = 3;

  localparam logic [3:0] OFF_COUNT = 4'h0;
  localparam logic [3:0] OFF_PRI   = 4'h4;
  localparam logic [3:0] OFF_SEC   = 4'h8;

  localparam logic [DATA_W-CNT_W-1:0] GUARD_COUNT = 16'h5A5A;
  localparam logic [DATA_W-REG_W-1:0] GUARD_CTRL  = 24'hA5A5A5;

  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_BUSY = 5;
  localparam int unsigned BIT_OVF  = 4;

  // divisor exponent for each select code
  function automatic logic [3:0] div_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    div_shift = 4'd0;
      3'd1:    div_shift = 4'd2;
      3'd2:    div_shift = 4'd4;
      3'd3:    div_shift = 4'd5;
      3'd4:    div_shift = 4'd6;
      3'd5:    div_shift = 4'd7;
      3'd6:    div_shift = 4'd10;
      default: div_shift = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/kwdt_decode.sv
module kwdt_decode
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wr_count,
  output logic              wr_pri,
  output logic              wr_sec
);
  logic wr_any;
  logic count_key_ok;
  logic ctrl_key_ok;

  always_comb begin
    wr_any       = bus_sel && bus_we;
    count_key_ok = (bus_wdata[DATA_W-1:CNT_W] == GUARD_COUNT);
    ctrl_key_ok  = (bus_wdata[DATA_W-1:REG_W] == GUARD_CTRL);
    wr_count     = wr_any && count_key_ok && (bus_addr == ADDR_W'(OFF_COUNT));
    wr_pri       = wr_any && ctrl_key_ok  && (bus_addr == ADDR_W'(OFF_PRI));
    wr_sec       = wr_any && ctrl_key_ok  && (bus_addr == ADDR_W'(OFF_SEC));
  end
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale
  import keyed_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ls,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    pre_d = pre_q + PRE_W'(1);
    mask  = PRE_W'((32'd1 << div_shift(div_sel)) - 32'd1);
    tick  = &(pre_q | ~mask);
  end

  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned PEND_TICKS = 2,
  localparam int unsigned PEND_W    = $clog2(PEND_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_ls,
  input  logic             tick,
  input  logic             run_en,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             busy,
  output logic             wrap
);
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  stage_q;
  logic [CNT_W-1:0]  stage_d;
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_d;
  logic              apply;
  logic              stage_en;

  always_comb begin
    stage_en = load_req;
    stage_d  = load_val;
    apply    = tick && (pend_q == PEND_W'(1)) && !load_req;
    if (load_req)
      pend_d = PEND_W'(PEND_TICKS);
    else if (tick && (pend_q != '0))
      pend_d = pend_q - PEND_W'(1);
    else
      pend_d = pend_q;
    wrap = run_en && tick && !apply && (cnt_q == {CNT_W{1'b1}});
    if (apply)
      cnt_d = stage_q;
    else if (run_en && tick)
      cnt_d = cnt_q + CNT_W'(1);
    else
      cnt_d = cnt_q;
    busy = (pend_q != '0);
  end

  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls)       stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end
endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import keyed_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ls,
  input  logic             wr_pri,
  input  logic             wr_sec,
  input  logic [REG_W-1:0] wr_byte,
  input  logic             wrap,
  output logic             en_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             ovf_q,
  output logic [REG_W-1:0] sec_q,
  output logic             rst_req_q
);
  logic             en_d;
  logic [SEL_W-1:0] sel_d;
  logic             ovf_d;
  logic [REG_W-1:0] sec_d;
  logic             unused_bits;

  assign unused_bits = ^{wr_byte[6:5], wr_byte[3]};

  always_comb begin
    en_d  = wr_pri ? wr_byte[BIT_EN] : en_q;
    sel_d = wr_pri ? wr_byte[SEL_W-1:0] : sel_q;
    sec_d = wr_sec ? wr_byte : sec_q;
    if (wrap)
      ovf_d = 1'b1;
    else if (wr_pri && !wr_byte[BIT_OVF])
      ovf_d = 1'b0;
    else
      ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls) begin
      en_q      <= 1'b0;
      sel_q     <= '0;
      ovf_q     <= 1'b0;
      sec_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      en_q      <= en_d;
      sel_q     <= sel_d;
      ovf_q     <= ovf_d;
      sec_q     <= sec_d;
      rst_req_q <= wrap;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned PEND_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_req
);
  logic [1:0]       rst_sync_q;
  logic             rst_ls;
  logic             wr_count;
  logic             wr_pri;
  logic             wr_sec;
  logic             tick;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             ovf_q;
  logic [REG_W-1:0] sec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy;
  logic             wrap;
  logic [REG_W-1:0] pri_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ls = rst_sync_q[1];

  kwdt_decode #(.ADDR_W(ADDR_W)) decode_i (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wr_count  (wr_count),
    .wr_pri    (wr_pri),
    .wr_sec    (wr_sec)
  );

  kwdt_prescale prescale_i (
    .clk     (clk),
    .rst_ls  (rst_ls),
    .div_sel (sel_q),
    .tick    (tick)
  );

  kwdt_counter #(.PEND_TICKS(PEND_TICKS)) counter_i (
    .clk      (clk),
    .rst_ls   (rst_ls),
    .tick     (tick),
    .run_en   (en_q),
    .load_req (wr_count),
    .load_val (bus_wdata[CNT_W-1:0]),
    .cnt_q    (cnt_q),
    .busy     (busy),
    .wrap     (wrap)
  );

  kwdt_ctrl ctrl_i (
    .clk       (clk),
    .rst_ls    (rst_ls),
    .wr_pri    (wr_pri),
    .wr_sec    (wr_sec),
    .wr_byte   (bus_wdata[REG_W-1:0]),
    .wrap      (wrap),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .ovf_q     (ovf_q),
    .sec_q     (sec_q),
    .rst_req_q (wdt_rst_req)
  );

  always_comb begin
    pri_view = {en_q, 1'b0, busy, ovf_q, 1'b0, sel_q};
    if (bus_addr == ADDR_W'(OFF_COUNT))
      bus_rdata = DATA_W'(cnt_q);
    else if (bus_addr == ADDR_W'(OFF_PRI))
      bus_rdata = DATA_W'(pri_view);
    else if (bus_addr == ADDR_W'(OFF_SEC))
      bus_rdata = DATA_W'(sec_q);
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_ls,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wdt_rst_req,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [REG_W-1:0]  sec_q,
  input logic              en_q,
  input logic              ovf_q,
  input logic              busy,
  input logic              tick
);
  logic good_count_wr;
  logic bad_sec_wr;
  logic ovf_clear_wr;

  always_comb begin
    good_count_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_COUNT)) &&
                    (bus_wdata[31:16] == 16'h5A5A);
    bad_sec_wr    = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_SEC)) &&
                    (bus_wdata[31:8] != 24'hA5A5A5);
    ovf_clear_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_PRI)) &&
                    (bus_wdata[31:8] == 24'hA5A5A5) && !bus_wdata[4];
  end

  // R5
  busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    good_count_wr |=> busy);

  // R9
  req_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    wdt_rst_req |-> ovf_q);

  // R9
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    wdt_rst_req |=> !wdt_rst_req);

  // R2
  bad_key_sec_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    bad_sec_wr |=> $stable(sec_q));

  // R8
  halted_count_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    (!en_q && !busy) |=> $stable(cnt_q));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    (en_q && tick && !busy && (cnt_q != 16'hFFFF)) |=> (cnt_q == $past(cnt_q) + 16'd1));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    (ovf_q && !ovf_clear_wr) |=> ovf_q);
endmodule

bind keyed_wdt keyed_wdt_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_ls      (rst_ls),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .wdt_rst_req (wdt_rst_req),
  .cnt_q       (cnt_q),
  .sec_q       (sec_q),
  .en_q        (en_q),
  .ovf_q       (ovf_q),
  .busy        (busy),
  .tick        (tick)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int total;
  int bad;

  keyed_wdt dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdt_rst_req (wdt_rst_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // entry: {req[3:0], op(0 write / 1 read-check), addr[3:0], data[31:0], idle[7:0]}
  localparam int NVEC = 21;
  localparam logic [48:0] VEC [NVEC] = '{
    {4'd3,  1'b0, 4'h8, 32'hA5A5A53C, 8'd0},  // R3 keyed secondary write
    {4'd3,  1'b1, 4'h8, 32'h0000003C, 8'd0},  // R3 read back
    {4'd2,  1'b0, 4'h8, 32'h12A5A5FF, 8'd0},  // R2 wrong guard
    {4'd2,  1'b1, 4'h8, 32'h0000003C, 8'd0},  // R2 unchanged
    {4'd4,  1'b0, 4'h0, 32'h5A5A1234, 8'd0},  // R4 keyed count write
    {4'd5,  1'b1, 4'h4, 32'h00000020, 8'd0},  // R5 busy set
    {4'd5,  1'b1, 4'h0, 32'h00000000, 8'd2},  // R5 old count still visible
    {4'd4,  1'b1, 4'h0, 32'h00001234, 8'd0},  // R4 new count landed
    {4'd5,  1'b1, 4'h4, 32'h00000000, 8'd0},  // R5 busy clear
    {4'd6,  1'b0, 4'h4, 32'hA5A5A56B, 8'd0},  // R6 select 3, stray bits 6/5/3
    {4'd6,  1'b1, 4'h4, 32'h00000003, 8'd0},  // R6 only select stored
    {4'd2,  1'b0, 4'h4, 32'h5A5A5A85, 8'd0},  // R2 wrong guard
    {4'd2,  1'b1, 4'h4, 32'h00000003, 8'd0},  // R2 unchanged
    {4'd6,  1'b0, 4'h4, 32'hA5A5A500, 8'd0},  // R6 back to select 0
    {4'd6,  1'b1, 4'h4, 32'h00000000, 8'd0},  // R6
    {4'd2,  1'b0, 4'h0, 32'h5A5BFFFF, 8'd3},  // R2 wrong count guard
    {4'd2,  1'b1, 4'h0, 32'h00001234, 8'd0},  // R2 count unchanged
    {4'd2,  1'b1, 4'h4, 32'h00000000, 8'd0},  // R2 no busy raised
    {4'd12, 1'b1, 4'hC, 32'h00000000, 8'd0},  // R12 unmapped read
    {4'd4,  1'b0, 4'h0, 32'h5A5A0000, 8'd2},  // R4 load zero
    {4'd4,  1'b1, 4'h0, 32'h00000000, 8'd0}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic int divisor(input int s);
    case (s)
      0: return 1;    1: return 4;    2: return 16;   3: return 32;
      4: return 64;   5: return 128;  6: return 1024; default: return 4096;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] x;
    logic [31:0] y;
    total = 0; bad = 0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    rd(4'h0, v); chk("R1 count", v, 32'h0);
    rd(4'h4, v); chk("R1 primary", v, 32'h0);
    rd(4'h8, v); chk("R1 secondary", v, 32'h0);
    chk("R1 rst_req", {31'd0, wdt_rst_req}, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      logic [48:0] e;
      e = VEC[k];
      if (e[44] == 1'b0) wr(e[43:40], e[39:8]);
      else begin
        rd(e[43:40], v);
        chk($sformatf("R%0d vector %0d", e[48:45], k), v, e[39:8]);
      end
      wait_cyc(int'(e[7:0]));
    end

    // R7 / R9: count up to rollover at divisor 1
    wr(4'h0, 32'h5A5AFFF0); wait_cyc(2);
    wr(4'h4, 32'hA5A5A580);
    rd(4'h0, v); chk("R7 start value", v, 32'h0000FFF0);
    wait_cyc(5);
    rd(4'h0, v); chk("R7 five ticks", v, 32'h0000FFF5);
    wait_cyc(10);
    rd(4'h0, v); chk("R9 at max", v, 32'h0000FFFF);
    chk("R9 no early request", {31'd0, wdt_rst_req}, 32'h0);
    wait_cyc(1);
    rd(4'h0, v); chk("R9 wrapped", v, 32'h0);
    rd(4'h4, v); chk("R9 flag set", v, 32'h00000090);
    chk("R9 request high", {31'd0, wdt_rst_req}, 32'h1);
    wait_cyc(1);
    chk("R9 request one cycle", {31'd0, wdt_rst_req}, 32'h0);
    rd(4'h0, v); chk("R9 counts on", v, 32'h1);

    // R10 flag clear semantics
    wr(4'h4, 32'hA5A5A590);
    rd(4'h4, v); chk("R10 write 1 keeps flag", v, 32'h00000090);
    wr(4'h4, 32'hA5A5A580);
    rd(4'h4, v); chk("R10 write 0 clears", v, 32'h00000080);

    // R8 stop and resume
    wr(4'h4, 32'hA5A5A500);
    rd(4'h0, x);
    wait_cyc(5);
    rd(4'h0, v); chk("R8 frozen", v, x);
    wr(4'h4, 32'hA5A5A580);
    rd(4'h0, v); chk("R8 resume value", v, x);
    wait_cyc(3);
    rd(4'h0, v); chk("R8 resumed counting", v, x + 32'd3);

    // R11 refresh while running
    wr(4'h0, 32'h5A5A0100);
    rd(4'h4, v); chk("R11 busy while enabled", v, 32'h000000A0);
    rd(4'h0, y);
    wait_cyc(1);
    rd(4'h0, v); chk("R11 old count advances", v, y + 32'd1);
    wait_cyc(1);
    rd(4'h0, v); chk("R11 new count landed", v, 32'h00000100);
    rd(4'h4, v); chk("R11 busy cleared", v, 32'h00000080);
    wait_cyc(1);
    rd(4'h0, v); chk("R11 counting from new", v, 32'h00000101);

    // R7 / R5 divisors
    wr(4'h4, 32'hA5A5A500);
    for (int s = 0; s < 8; s++) begin
      int d;
      d = divisor(s);
      wr(4'h4, 32'hA5A5A500 | 32'(s));
      wr(4'h0, 32'h5A5A0000);
      if (d >= 1024) begin
        wait_cyc(1000);
        rd(4'h4, v); chk($sformatf("R5 busy held sel %0d", s), v & 32'h20, 32'h20);
      end
      for (int t = 0; t < 10000; t++) begin
        rd(4'h4, v);
        if (v[5] == 1'b0) break;
        wait_cyc(1);
      end
      rd(4'h4, v); chk($sformatf("R5 busy cleared sel %0d", s), v & 32'h20, 32'h0);
      wr(4'h4, 32'hA5A5A580 | 32'(s));
      rd(4'h0, x);
      wait_cyc(2 * d);
      rd(4'h0, v); chk($sformatf("R7 two ticks sel %0d", s), v, x + 32'd2);
      wr(4'h4, 32'hA5A5A500);
    end

    // R12 unmapped write ignored
    wr(4'hC, 32'hA5A5A5FF);
    rd(4'h8, v); chk("R12 secondary untouched", v, 32'h0000003C);
    rd(4'h4, v); chk("R12 primary untouched", v, 32'h0);
    rd(4'hC, v); chk("R12 unmapped reads zero", v, 32'h0);

    // R1 reset during operation
    wr(4'h4, 32'hA5A5A581);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    rd(4'h4, v); chk("R1 primary after reset", v, 32'h0);
    rd(4'h8, v); chk("R1 secondary after reset", v, 32'h0);
    rd(4'h0, v); chk("R1 count after reset", v, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule